// File: doc/BRIEF.md
# External Bus Strobe Timing Sequencer

This block sits between an on-chip requester and a parallel external bus. It turns one internal read or write request into one external bus cycle. For that cycle it drives an active-low address strobe, one active-low chip select per area, an active-low read strobe and an active-low write strobe. It also drives the address and the write data, together with an output-enable for the data pins. Each request names an area (0 to 7), a direction, an address and write data. The block takes the request with a one-cycle acceptance pulse and later reports completion with a one-cycle done pulse. Read data is captured from the bus at the end of the read strobe cycle.

Each area has three timing bits. Each bit adds exactly one clock cycle at a fixed point of the cycle:
- The setup bit puts a cycle between chip select going active and the strobe going active.
- The hold bit puts a cycle between the strobe releasing and chip select releasing.
- The address bit shows the address for a cycle before chip select and keeps it for a cycle after.

The bits are sampled when a request is taken.

If the next request is already waiting during the strobe cycle and targets the same area, it is taken in that cycle. Chip select then stays active and the new strobe cycle follows at once, with no setup or hold cycle between the two accesses.

Top module: `xbus_seq`

## Requirements
- R1: When bit a of `cfg_setup` is 1, an access to area a has exactly one cycle in which chip select a is low and both strobes are high, before the strobe cycle; when it is 0 there is none.
- R2: When bit a of `cfg_hold` is 1, exactly one cycle with chip select a low and both strobes high follows the strobe cycle; when it is 0, chip select releases in the cycle right after the strobe cycle.
- R3: The setup and hold bits act independently; all four combinations give the cycle counts of R1 and R2, and every access has exactly one strobe cycle.
- R4: A request taken during a strobe cycle for the same area (same-area back-to-back) keeps that chip select low without a break. The next strobe cycle follows at once, with no setup or hold cycle between the two accesses.
- R5: When bit a of `cfg_adly` is 1, the address is driven for one cycle with all chip selects high before chip select a goes low. One further cycle with chip selects high passes after it releases before a new request can be taken.
- R6: With all three bits of the area at 0, chip select and the strobe are low in the same single cycle, which is the first cycle after the request is taken.
- R7: `bus_as_n` is low for exactly the first cycle of each access, and `bus_addr` changes only in such a cycle.
- R8: `done` is high for one cycle, the cycle after each strobe cycle. After a read, `rdata` holds the value of `bus_din` at the end of the read strobe cycle until the next read.
- R9: `bus_doe` is high only in write strobe cycles and in the hold cycle that follows a write. During a write strobe, `bus_dout` equals the request's write data.
- R10: At most one chip select is low. A pending request for a different area is not taken while chip select is low; it is taken in the first idle cycle.
- R11: The timing bits are sampled when a request is taken; changing them later has no effect on that access.
- R12: During reset `req_take` is 0. After reset all chip selects and all strobes are high (inactive), `bus_doe` and `done` are 0, and `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request pending; the request fields are held until taken |
| req_area | input | 3 | Target area index |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| req_take | output | 1 | Request taken at this clock edge |
| cfg_setup | input | NAREA | Per-area setup-cycle enable |
| cfg_hold | input | NAREA | Per-area hold-cycle enable |
| cfg_adly | input | NAREA | Per-area address setup/hold enable |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DW | Captured read data |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_cs_n | output | NAREA | Chip selects, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_addr | output | AW | External address |
| bus_dout | output | DW | Data driven to the bus |
| bus_doe | output | 1 | Data pin output enable |
| bus_din | input | DW | Data read from the bus |

## Verification
The bench walks every area, so each combination of the three timing bits is seen. It counts, cycle by cycle, the address-only cycles, the setup cycles, the strobe cycles and the hold cycles. A sequencer that tied the hold cycle to the setup bit, or dropped the address hold cycle, shows up as a wrong count. A wrong count also shows at the gap before the next request is taken.

A same-area request waiting during the strobe cycle must merge, with chip select never released and no extra setup or hold cycle between the two accesses. A design that re-entered the setup phase would show two setup cycles there. A waiting request for another area must not merge: a design that merged it would switch chip selects without a break.

The timing bits are flipped right after a request is taken. A design that read them live instead of latching them would change the cycle counts of the access already running.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_APRE,
        ST_CSET,
        ST_STRB,
        ST_CHLD,
        ST_APOST
    } bus_state_t;

    typedef struct packed {
        logic setup;
        logic hold;
        logic adly;
    } tcfg_t;

    // first state of a freshly started access
    function automatic bus_state_t entry_state(tcfg_t c);
        if (c.adly)
            return ST_APRE;
        else if (c.setup)
            return ST_CSET;
        else
            return ST_STRB;
    endfunction

    // state after the last strobe cycle when no merge happens
    function automatic bus_state_t exit_state(tcfg_t c);
        if (c.hold)
            return ST_CHLD;
        else if (c.adly)
            return ST_APOST;
        else
            return ST_IDLE;
    endfunction

    function automatic logic cs_phase(bus_state_t s);
        return (s == ST_CSET) || (s == ST_STRB) || (s == ST_CHLD);
    endfunction

endpackage

// File: rtl/xbus_cfgsel.sv
module xbus_cfgsel
    import xbus_pkg::*;
#(
    parameter int NAREA = 8,
    localparam int AREA_W = $clog2(NAREA)
) (
    input  logic [NAREA-1:0]  cfg_setup,
    input  logic [NAREA-1:0]  cfg_hold,
    input  logic [NAREA-1:0]  cfg_adly,
    input  logic [AREA_W-1:0] area,
    output tcfg_t             sel
);

    tcfg_t per_area [NAREA];

    for (genvar g = 0; g < NAREA; g++) begin : g_area
        assign per_area[g] = '{setup: cfg_setup[g], hold: cfg_hold[g], adly: cfg_adly[g]};
    end

    assign sel = per_area[area];

endmodule

// File: rtl/xbus_fsm.sv
module xbus_fsm
    import xbus_pkg::*;
#(
    parameter int NAREA = 8,
    parameter int AW = 16,
    parameter int DW = 16,
    localparam int AREA_W = $clog2(NAREA)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [AREA_W-1:0] req_area,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    input  tcfg_t             new_cfg,
    output logic              req_take,
    output bus_state_t        st,
    output logic              first,
    output logic [AREA_W-1:0] acc_area,
    output logic              acc_write,
    output logic [AW-1:0]     acc_addr,
    output logic [DW-1:0]     acc_wdata,
    output tcfg_t             acc_cfg
);

    bus_state_t        st_q, st_d;
    logic              take;
    logic              same_area;
    logic              first_q;
    logic [AREA_W-1:0] area_q;
    logic              write_q;
    logic [AW-1:0]     addr_q;
    logic [DW-1:0]     wdata_q;
    tcfg_t             cfg_q;

    assign same_area = (req_area == area_q);

    // a request is taken when idle, or merged during a same-area strobe cycle
    always_comb begin
        take = 1'b0;
        if (!rst && req_valid) begin
            if (st_q == ST_IDLE)
                take = 1'b1;
            else if (st_q == ST_STRB && same_area)
                take = 1'b1;
        end
    end

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE:  if (take) st_d = entry_state(new_cfg);
            ST_APRE:  st_d = cfg_q.setup ? ST_CSET : ST_STRB;
            ST_CSET:  st_d = ST_STRB;
            ST_STRB:  st_d = take ? ST_STRB : exit_state(cfg_q);
            ST_CHLD:  st_d = cfg_q.adly ? ST_APOST : ST_IDLE;
            ST_APOST: st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            first_q <= 1'b0;
            area_q  <= '0;
            write_q <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            cfg_q   <= '0;
        end else begin
            st_q    <= st_d;
            first_q <= take;
            if (take) begin
                area_q  <= req_area;
                write_q <= req_write;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                cfg_q   <= new_cfg;
            end
        end
    end

    assign req_take  = take;
    assign st        = st_q;
    assign first     = first_q;
    assign acc_area  = area_q;
    assign acc_write = write_q;
    assign acc_addr  = addr_q;
    assign acc_wdata = wdata_q;
    assign acc_cfg   = cfg_q;

endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
    import xbus_pkg::*;
#(
    parameter int NAREA = 8,
    parameter int AW = 16,
    parameter int DW = 16,
    localparam int AREA_W = $clog2(NAREA)
) (
    input  bus_state_t        st,
    input  logic              first,
    input  logic [AREA_W-1:0] acc_area,
    input  logic              acc_write,
    input  logic [AW-1:0]     acc_addr,
    input  logic [DW-1:0]     acc_wdata,
    output logic              bus_as_n,
    output logic [NAREA-1:0]  bus_cs_n,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic [AW-1:0]     bus_addr,
    output logic [DW-1:0]     bus_dout,
    output logic              bus_doe
);

    logic in_cs;
    logic in_strb;

    assign in_cs   = cs_phase(st);
    assign in_strb = (st == ST_STRB);

    for (genvar g = 0; g < NAREA; g++) begin : g_cs
        assign bus_cs_n[g] = ~(in_cs && (acc_area == AREA_W'(g)));
    end

    assign bus_as_n = ~first;
    assign bus_rd_n = ~(in_strb && !acc_write);
    assign bus_wr_n = ~(in_strb && acc_write);
    assign bus_doe  = acc_write && (in_strb || st == ST_CHLD);
    assign bus_addr = acc_addr;
    assign bus_dout = acc_wdata;

endmodule

// File: rtl/xbus_rcap.sv
module xbus_rcap
    import xbus_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_state_t    st,
    input  logic          acc_write,
    input  logic [DW-1:0] bus_din,
    output logic          done,
    output logic [DW-1:0] rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            done  <= 1'b0;
            rdata <= '0;
        end else begin
            done <= (st == ST_STRB);
            if (st == ST_STRB && !acc_write)
                rdata <= bus_din;
        end
    end

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int NAREA = 8,
    parameter int AW = 16,
    parameter int DW = 16,
    localparam int AREA_W = $clog2(NAREA)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [AREA_W-1:0] req_area,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    output logic              req_take,
    input  logic [NAREA-1:0]  cfg_setup,
    input  logic [NAREA-1:0]  cfg_hold,
    input  logic [NAREA-1:0]  cfg_adly,
    output logic              done,
    output logic [DW-1:0]     rdata,
    output logic              bus_as_n,
    output logic [NAREA-1:0]  bus_cs_n,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic [AW-1:0]     bus_addr,
    output logic [DW-1:0]     bus_dout,
    output logic              bus_doe,
    input  logic [DW-1:0]     bus_din
);

    tcfg_t             new_cfg;
    tcfg_t             acc_cfg;
    bus_state_t        st;
    logic              first;
    logic [AREA_W-1:0] acc_area;
    logic              acc_write;
    logic [AW-1:0]     acc_addr;
    logic [DW-1:0]     acc_wdata;

    xbus_cfgsel #(.NAREA(NAREA)) u_cfgsel (
        .cfg_setup (cfg_setup),
        .cfg_hold  (cfg_hold),
        .cfg_adly  (cfg_adly),
        .area      (req_area),
        .sel       (new_cfg)
    );

    xbus_fsm #(.NAREA(NAREA), .AW(AW), .DW(DW)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_area  (req_area),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .new_cfg   (new_cfg),
        .req_take  (req_take),
        .st        (st),
        .first     (first),
        .acc_area  (acc_area),
        .acc_write (acc_write),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .acc_cfg   (acc_cfg)
    );

    xbus_pins #(.NAREA(NAREA), .AW(AW), .DW(DW)) u_pins (
        .st        (st),
        .first     (first),
        .acc_area  (acc_area),
        .acc_write (acc_write),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .bus_as_n  (bus_as_n),
        .bus_cs_n  (bus_cs_n),
        .bus_rd_n  (bus_rd_n),
        .bus_wr_n  (bus_wr_n),
        .bus_addr  (bus_addr),
        .bus_dout  (bus_dout),
        .bus_doe   (bus_doe)
    );

    xbus_rcap #(.DW(DW)) u_rcap (
        .clk       (clk),
        .rst       (rst),
        .st        (st),
        .acc_write (acc_write),
        .bus_din   (bus_din),
        .done      (done),
        .rdata     (rdata)
    );

endmodule

// File: rtl/xbus_seq_chk.sv
module xbus_seq_chk
    import xbus_pkg::*;
#(
    parameter int NAREA = 8,
    parameter int AW = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [NAREA-1:0] bus_cs_n,
    input logic             bus_rd_n,
    input logic             bus_wr_n,
    input logic             bus_as_n,
    input logic [AW-1:0]    bus_addr,
    input logic             bus_doe,
    input logic             done,
    input logic             req_take,
    input tcfg_t            acc_cfg
);

    logic cs_any;
    logic strobe_on;

    assign cs_any    = ~&bus_cs_n;
    assign strobe_on = !bus_rd_n || !bus_wr_n;

    // R10: never two chip selects at once
    p_cs_onehot_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~bus_cs_n));

    // R1: first chip select cycle carries the strobe only without a setup cycle
    p_setup_gap_r1: assert property (@(posedge clk) disable iff (rst)
        ($past(!cs_any) && cs_any) |-> (strobe_on == !acc_cfg.setup));

    // R2: chip select outlives the strobe by one cycle only with the hold bit
    p_hold_gap_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(strobe_on) && !strobe_on) |-> (cs_any == acc_cfg.hold));

    // R6: a strobe only ever appears inside chip select
    p_strobe_in_cs_r6: assert property (@(posedge clk) disable iff (rst)
        strobe_on |-> cs_any);

    // R7: the address moves only in an address strobe cycle
    p_addr_on_as_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(bus_addr) |-> !bus_as_n);

    // R9: data pins driven only while chip select is active and no read
    p_drive_write_r9: assert property (@(posedge clk) disable iff (rst)
        bus_doe |-> (cs_any && bus_rd_n));

    // R8: completion follows a strobe cycle
    p_done_after_strobe_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(strobe_on));

    // R4: a merge during a strobe keeps chip select and strobes going
    p_merge_keeps_cs_r4: assert property (@(posedge clk) disable iff (rst)
        (req_take && strobe_on) |=> ($stable(bus_cs_n) && strobe_on));

endmodule

bind xbus_seq xbus_seq_chk #(.NAREA(NAREA), .AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_cs_n (bus_cs_n),
    .bus_rd_n (bus_rd_n),
    .bus_wr_n (bus_wr_n),
    .bus_as_n (bus_as_n),
    .bus_addr (bus_addr),
    .bus_doe  (bus_doe),
    .done     (done),
    .req_take (req_take),
    .acc_cfg  (acc_cfg)
);

// File: tb/xbus_seq_tb_top.sv
module xbus_seq_tb_top;

    localparam int NAREA = 8;
    localparam int AW = 16;
    localparam int DW = 16;

    // area index bits encode the configuration: bit0 setup, bit1 hold, bit2 address delay
    localparam logic [7:0] SETUP_MAP = 8'hAA;
    localparam logic [7:0] HOLD_MAP  = 8'hCC;
    localparam logic [7:0] ADLY_MAP  = 8'hF0;

    typedef struct packed {
        logic [2:0]  a;
        logic        w;
        logic [15:0] ad;
        logic [15:0] wd;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{3'd0, 1'b0, 16'h1000, 16'h0000},
        '{3'd5, 1'b1, 16'h2004, 16'hBEEF},
        '{3'd2, 1'b0, 16'h3008, 16'h0000},
        '{3'd7, 1'b1, 16'h400C, 16'h1234},
        '{3'd1, 1'b1, 16'h5010, 16'hCAFE},
        '{3'd4, 1'b0, 16'h6014, 16'h0000},
        '{3'd3, 1'b0, 16'h7018, 16'h0000},
        '{3'd6, 1'b1, 16'h801C, 16'h0F0F}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic [2:0]       req_area = '0;
    logic             req_write = 1'b0;
    logic [AW-1:0]    req_addr = '0;
    logic [DW-1:0]    req_wdata = '0;
    logic             req_take;
    logic [NAREA-1:0] cfg_setup = SETUP_MAP;
    logic [NAREA-1:0] cfg_hold  = HOLD_MAP;
    logic [NAREA-1:0] cfg_adly  = ADLY_MAP;
    logic             done;
    logic [DW-1:0]    rdata;
    logic             bus_as_n;
    logic [NAREA-1:0] bus_cs_n;
    logic             bus_rd_n;
    logic             bus_wr_n;
    logic [AW-1:0]    bus_addr;
    logic [DW-1:0]    bus_dout;
    logic             bus_doe;
    logic [DW-1:0]    bus_din;

    always #5 clk = ~clk;

    // external device model: read data is a fixed function of the address
    function automatic logic [DW-1:0] dev_val(logic [AW-1:0] a);
        return a ^ 16'hA5C3;
    endfunction

    assign bus_din = dev_val(bus_addr);

    xbus_seq #(.NAREA(NAREA), .AW(AW), .DW(DW)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_area  (req_area),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_take  (req_take),
        .cfg_setup (cfg_setup),
        .cfg_hold  (cfg_hold),
        .cfg_adly  (cfg_adly),
        .done      (done),
        .rdata     (rdata),
        .bus_as_n  (bus_as_n),
        .bus_cs_n  (bus_cs_n),
        .bus_rd_n  (bus_rd_n),
        .bus_wr_n  (bus_wr_n),
        .bus_addr  (bus_addr),
        .bus_dout  (bus_dout),
        .bus_doe   (bus_doe),
        .bus_din   (bus_din)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    // per-access measurements
    int pre, setc, strc, hldc, aslow, donec, doe_bad, cs_bad, waits;
    bit took_next;
    logic [DW-1:0] exp_rdata = '0;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d", what, act, exp);
        end
    endtask

    task automatic do_access(
        input logic [2:0] a, input logic w, input logic [15:0] ad, input logic [15:0] wd,
        input bit nx, input logic [2:0] na, input logic nw, input logic [15:0] nad,
        input logic [15:0] nwd, input bit flip);
        logic cw;
        logic [15:0] cad;
        logic [15:0] cwd;
        logic csl;
        logic strobe;
        bit seen;
        bit drop;
        req_valid = 1'b1;
        req_area  = a;
        req_write = w;
        req_addr  = ad;
        req_wdata = wd;
        waits = 0;
        #1;
        while (!req_take && waits < 20) begin
            @(negedge clk);
            #1;
            waits++;
        end
        pre = 0; setc = 0; strc = 0; hldc = 0; aslow = 0; donec = 0;
        doe_bad = 0; cs_bad = 0; took_next = 0;
        cw = w; cad = ad; cwd = wd; seen = 0; drop = 0;
        for (int k = 0; k < 24; k++) begin
            @(negedge clk);
            #1;
            if (k == 0) begin
                if (nx) begin
                    req_area  = na;
                    req_write = nw;
                    req_addr  = nad;
                    req_wdata = nwd;
                end else begin
                    req_valid = 1'b0;
                end
                if (flip) begin
                    cfg_setup = '0;
                    cfg_hold  = '1;
                end
            end
            if (drop) begin
                req_valid = 1'b0;
                drop = 0;
            end
            #1;
            csl    = !bus_cs_n[a];
            strobe = !bus_rd_n || !bus_wr_n;
            if ((bus_cs_n | (8'b1 << a)) != 8'hFF) cs_bad++;
            if (done) donec++;
            if (!bus_as_n) aslow++;
            if (!csl) begin
                if (seen) break;
                pre++;
                if (bus_doe || strobe || bus_addr != cad) doe_bad++;
            end else begin
                seen = 1;
                if (strobe) begin
                    strc++;
                    if ((!bus_wr_n) != cw || (!bus_rd_n) != !cw || bus_doe != cw ||
                        bus_addr != cad || (cw && bus_dout != cwd))
                        doe_bad++;
                    if (!cw) exp_rdata = dev_val(bus_addr);
                end else if (strc == 0) begin
                    setc++;
                    if (bus_doe) doe_bad++;
                end else begin
                    hldc++;
                    if (bus_doe != cw) doe_bad++;
                end
            end
            if (nx && !took_next && req_take) begin
                took_next = 1;
                cw = nw; cad = nad; cwd = nwd;
                drop = 1;
            end
        end
    endtask

    initial begin
        int prev_d;
        // R12: reset state, request refused during reset
        req_valid = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk(req_take == 1'b0, "R12 take during reset", int'(req_take), 0);
        req_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk(bus_cs_n == 8'hFF && bus_rd_n && bus_wr_n && bus_as_n, "R12 idle strobes",
            int'({bus_cs_n, bus_rd_n, bus_wr_n, bus_as_n}), 16'h7FF);
        chk(!bus_doe && !done && rdata == '0, "R12 idle doe/done/rdata",
            int'({bus_doe, done}) + int'(rdata), 0);

        // table walk: each area = one timing combination (R1 R2 R3 R5 R6)
        prev_d = 0;
        for (int i = 0; i < 8; i++) begin
            logic s, h, d;
            s = VEC[i].a[0];
            h = VEC[i].a[1];
            d = VEC[i].a[2];
            do_access(VEC[i].a, VEC[i].w, VEC[i].ad, VEC[i].wd, 0, 3'd0, 1'b0, 16'h0, 16'h0, 0);
            chk(waits == prev_d, $sformatf("R5 take gap after area before %0d", VEC[i].a), waits, prev_d);
            chk(pre == int'(d), $sformatf("R5 address-only cycles area %0d", VEC[i].a), pre, int'(d));
            chk(setc == int'(s), $sformatf("R1 setup cycles area %0d", VEC[i].a), setc, int'(s));
            chk(hldc == int'(h), $sformatf("R2 hold cycles area %0d", VEC[i].a), hldc, int'(h));
            chk(strc == 1, $sformatf("R3 R6 strobe cycles area %0d", VEC[i].a), strc, 1);
            chk(aslow == 1, $sformatf("R7 as_n low cycles area %0d", VEC[i].a), aslow, 1);
            chk(donec == 1, $sformatf("R8 done pulses area %0d", VEC[i].a), donec, 1);
            chk(rdata == exp_rdata, $sformatf("R8 read data area %0d", VEC[i].a), int'(rdata), int'(exp_rdata));
            chk(doe_bad == 0, $sformatf("R9 data drive/strobe errors area %0d", VEC[i].a), doe_bad, 0);
            chk(cs_bad == 0, $sformatf("R10 foreign chip select area %0d", VEC[i].a), cs_bad, 0);
            prev_d = int'(d);
        end

        // R4: same-area back-to-back, write then read, area 3 (setup and hold set)
        do_access(3'd3, 1'b1, 16'h9000, 16'hA55A, 1, 3'd3, 1'b0, 16'h9002, 16'h0, 0);
        chk(took_next == 1, "R4 merge taken during strobe", int'(took_next), 1);
        chk(setc == 1 && hldc == 1, "R4 one setup and one hold across merge", setc * 10 + hldc, 11);
        chk(strc == 2, "R4 consecutive strobe cycles", strc, 2);
        chk(aslow == 2, "R7 as_n per merged access", aslow, 2);
        chk(donec == 2, "R8 done per merged access", donec, 2);
        chk(rdata == dev_val(16'h9002), "R8 merged read data", int'(rdata), int'(dev_val(16'h9002)));
        chk(doe_bad == 0, "R9 drive across merge", doe_bad, 0);

        // R10: different-area request pending during strobe is not merged
        do_access(3'd0, 1'b0, 16'hA000, 16'h0, 1, 3'd2, 1'b1, 16'hB000, 16'h7777, 0);
        chk(took_next == 0, "R10 other area not merged", int'(took_next), 0);
        chk(strc == 1 && hldc == 0, "R10 first access alone", strc * 10 + hldc, 10);
        do_access(3'd2, 1'b1, 16'hB000, 16'h7777, 0, 3'd0, 1'b0, 16'h0, 16'h0, 0);
        chk(waits == 0, "R10 taken in first idle cycle", waits, 0);
        chk(setc == 0 && hldc == 1 && strc == 1, "R10 second access timing",
            setc * 100 + hldc * 10 + strc, 11);
        chk(doe_bad == 0, "R9 write hold drive", doe_bad, 0);

        // R11: configuration flipped after take has no effect on area 1
        do_access(3'd1, 1'b0, 16'hC000, 16'h0, 0, 3'd0, 1'b0, 16'h0, 16'h0, 1);
        chk(setc == 1, "R11 latched setup bit", setc, 1);
        chk(hldc == 0, "R11 latched hold bit", hldc, 0);
        cfg_setup = SETUP_MAP;
        cfg_hold  = HOLD_MAP;

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule